// File: doc/BRIEF.md
# Repetitive Pattern Receive Synchronizer

This block locks onto a repeating bit pattern in a bit-serial received stream. The pattern is set by a pattern word and a length of 1 to 32 bits. Bit 0 of the word is the first bit of each repetition, and bit (length-1) is the last. While hunting, the block tests every received bit position as a possible phase of the repetition. When the most recent length-many bits match the word, it aligns its local pattern pointer so that the next expected bit is pattern bit 0.

After a candidate phase is found, the block checks the next 32 received bits against the aligned pattern. It declares lock only if all 32 match, and any mismatch sends it back to hunting. While locked, it flags every mismatch and counts mismatches in a saturating counter. It also watches error density in fixed, non-overlapping 64-bit windows. A sixth error inside one window sends it back to hunting unless automatic relock is disabled. A rising edge on the manual request restarts the hunt at any time. An invert control flips every received bit before any comparison.

Top module: `rptsync_top`

## Requirements
- R1: After reset, `in_sync` is 0, `err_flag` is 0, `err_cnt` is 0, and the block is hunting with no received bits yet considered.
- R2: While hunting, a candidate phase is found on the bit at which the last L received bits, counted since the hunt began, equal pattern bits 0..L-1 in arrival order, with the oldest bit compared to bit 0. Lock is never declared directly from the hunt.
- R3: After a candidate phase, lock (`in_sync`=1) is declared one clock after the 32nd consecutive matching check bit. The expected bits start from pattern bit 0.
- R4: A mismatch during the 32-bit check returns the block to hunting, which restarts with an empty bit history.
- R5: While locked, mismatches are totalled per 64-bit window. The first window starts at lock entry, and the windows do not overlap. The bit that brings a window's total to 6 makes `in_sync` fall one clock later.
- R6: When `auto_dis` is 1, error density never drops lock.
- R7: A 0-to-1 transition of `manual_req` returns the block to hunting, and `in_sync` is 0 on the next clock. The bit presented in that cycle is discarded. Holding `manual_req` high has no further effect.
- R8: When `inv_en` is 1, each received bit is inverted before hunting and checking.
- R9: While locked, each mismatching bit raises `err_flag` for exactly one clock and increments `err_cnt`, which saturates at its all-ones value. Mismatches outside lock change neither output.
- R10: The length is programmable from 1 to 32, and the expected pattern wraps from bit L-1 back to bit 0.
- R11: A clock with `rx_vld`=0 changes neither the lock state, the pattern position nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial bit |
| rx_vld | input | 1 | Qualifies `rx_bit` in this clock |
| pat_word | input | PAT_W | Repeating pattern, bit 0 first |
| pat_len | input | $clog2(PAT_W+1) | Pattern length L (1..PAT_W) |
| inv_en | input | 1 | Invert received bits before comparison |
| auto_dis | input | 1 | Disable automatic relock on error density |
| manual_req | input | 1 | Restart the hunt on a rising edge |
| in_sync | output | 1 | Locked to the pattern |
| err_flag | output | 1 | One-clock pulse per bit error while locked |
| err_cnt | output | CNT_W | Saturating bit-error count |

## Verification
The bench builds the block with a 32-bit pattern field and shrinks the error counter to 4 bits. This brings counter saturation at 15 within a few dozen injected errors. The default verify length of 32, window of 64 and limit of 6 are kept. As a result, the lock timing, the window wrap and the drop on the sixth error are checked at their real values. Runs at lengths 1, 7 and 32 cover both ends of the pointer wrap and a hunt that needs a full 32-bit history.

// File: rtl/rptsync_pkg.sv
package rptsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } sync_st_t;

  // Out-of-range lengths are forced into 1..maxw
  function automatic int clamp_len(input int raw, input int maxw);
    if (raw < 1) return 1;
    if (raw > maxw) return maxw;
    return raw;
  endfunction

  // Pattern pointer advance with wrap after bit len-1
  function automatic int step_ptr(input int p, input int len);
    if (p + 1 >= len) return 0;
    return p + 1;
  endfunction

endpackage

// File: rtl/rptsync_hunt.sv
module rptsync_hunt #(
  parameter int PAT_W = 32,
  parameter int LEN_W = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clr,
  input  logic             bit_in,
  input  logic [PAT_W-1:0] pat,
  input  logic [LEN_W-1:0] len,
  output logic             hit
);
  localparam int FILL_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0]  hist_q, hist_nxt;
  logic [FILL_W-1:0] fill_q, fill_nxt;

  // hist[0] is the newest bit; pattern bit k pairs with hist[n-1-k]
  function automatic logic tail_match(input logic [PAT_W-1:0] h,
                                      input logic [PAT_W-1:0] p,
                                      input int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < PAT_W; k++) begin
      if (k < n) begin
        if (p[k] != h[n-1-k]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  assign hist_nxt = {hist_q[PAT_W-2:0], bit_in};
  assign fill_nxt = (fill_q == FILL_W'(PAT_W)) ? fill_q : fill_q + 1'b1;
  assign hit = shift_en && (int'(fill_nxt) >= int'(len)) &&
               tail_match(hist_nxt, pat, int'(len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/rptsync_mon.sv
module rptsync_mon #(
  parameter int WIN_BITS = 64,
  parameter int ERR_LIM  = 6,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             hold_clr,
  input  logic             mism,
  input  logic             auto_dis,
  output logic             drop,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int WB_W = $clog2(WIN_BITS);
  localparam int WE_W = $clog2(WIN_BITS + 2);

  logic [WB_W-1:0] wbit_q;
  logic [WE_W-1:0] werr_q, werr_sum;
  logic            wrap;

  assign werr_sum = werr_q + WE_W'(mism);
  assign wrap     = (wbit_q == WB_W'(WIN_BITS - 1));
  assign drop     = active && !auto_dis && (werr_sum >= WE_W'(ERR_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbit_q   <= '0;
      werr_q   <= '0;
      err_flag <= 1'b0;
      err_cnt  <= '0;
    end else begin
      err_flag <= active && mism;
      if (active && mism && (err_cnt != '1)) err_cnt <= err_cnt + 1'b1;
      if (hold_clr) begin
        wbit_q <= '0;
        werr_q <= '0;
      end else if (active) begin
        if (wrap) begin
          wbit_q <= '0;
          werr_q <= '0;
        end else begin
          wbit_q <= wbit_q + 1'b1;
          werr_q <= werr_sum;
        end
      end
    end
  end
endmodule

// File: rtl/rptsync_top.sv
module rptsync_top
  import rptsync_pkg::*;
#(
  parameter int PAT_W       = 32,
  parameter int VERIFY_BITS = 32,
  parameter int WIN_BITS    = 64,
  parameter int ERR_LIM     = 6,
  parameter int CNT_W       = 16,
  parameter int LEN_W       = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_vld,
  input  logic [PAT_W-1:0] pat_word,
  input  logic [LEN_W-1:0] pat_len,
  input  logic             inv_en,
  input  logic             auto_dis,
  input  logic             manual_req,
  output logic             in_sync,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int PTR_W = $clog2(PAT_W);
  localparam int VC_W  = $clog2(VERIFY_BITS);

  sync_st_t         state_q;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [VC_W-1:0]  vcnt_q;
  logic             man_q;
  logic [LEN_W-1:0] len_eff;

  // named internal events
  logic data_bit, mism, man_rise, step;
  logic hunt_hit, vfy_done, vfy_fail, lock_act, drop_evt;

  assign len_eff  = LEN_W'(clamp_len(int'(pat_len), PAT_W));
  assign data_bit = rx_bit ^ inv_en;
  assign mism     = data_bit != pat_word[ptr_q];
  assign man_rise = manual_req & ~man_q;
  assign step     = rx_vld & ~man_rise;
  assign ptr_nxt  = PTR_W'(step_ptr(int'(ptr_q), int'(len_eff)));
  assign vfy_done = step && (state_q == ST_CHECK) && !mism &&
                    (vcnt_q == VC_W'(VERIFY_BITS - 1));
  assign vfy_fail = step && (state_q == ST_CHECK) && mism;
  assign lock_act = step && (state_q == ST_LOCK);
  assign in_sync  = (state_q == ST_LOCK);

  rptsync_hunt #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (step && (state_q == ST_HUNT)),
    .clr      ((state_q != ST_HUNT) || man_rise),
    .bit_in   (data_bit),
    .pat      (pat_word),
    .len      (len_eff),
    .hit      (hunt_hit)
  );

  rptsync_mon #(.WIN_BITS(WIN_BITS), .ERR_LIM(ERR_LIM), .CNT_W(CNT_W)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (lock_act),
    .hold_clr (state_q != ST_LOCK),
    .mism     (mism),
    .auto_dis (auto_dis),
    .drop     (drop_evt),
    .err_flag (err_flag),
    .err_cnt  (err_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      ptr_q   <= '0;
      vcnt_q  <= '0;
      man_q   <= 1'b0;
    end else begin
      man_q <= manual_req;
      if (man_rise) begin
        state_q <= ST_HUNT;
      end else if (rx_vld) begin
        unique case (state_q)
          ST_HUNT: if (hunt_hit) begin
            state_q <= ST_CHECK;
            ptr_q   <= '0;
            vcnt_q  <= '0;
          end
          ST_CHECK: begin
            if (vfy_fail) begin
              state_q <= ST_HUNT;
            end else begin
              ptr_q  <= ptr_nxt;
              vcnt_q <= vcnt_q + 1'b1;
              if (vfy_done) state_q <= ST_LOCK;
            end
          end
          ST_LOCK: begin
            ptr_q <= ptr_nxt;
            if (drop_evt) state_q <= ST_HUNT;
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rptsync_chk.sv
module rptsync_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_vld,
  input logic             auto_dis,
  input logic             in_sync,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_cnt,
  input logic             man_rise,
  input logic             vfy_done,
  input logic             drop_evt
);
  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(vfy_done));

  // R5
  sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> $past(drop_evt || man_rise));

  // R6
  auto_dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && auto_dis && !man_rise) |=> in_sync);

  // R7
  manual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rise |=> !in_sync);

  // R9
  flag_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $past(in_sync));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_flag && err_cnt == $past(err_cnt) + 1'b1));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_vld && !man_rise) |=> ($stable(in_sync) && !err_flag && $stable(err_cnt)));
endmodule

bind rptsync_top rptsync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_vld   (rx_vld),
  .auto_dis (auto_dis),
  .in_sync  (in_sync),
  .err_flag (err_flag),
  .err_cnt  (err_cnt),
  .man_rise (man_rise),
  .vfy_done (vfy_done),
  .drop_evt (drop_evt)
);

// File: tb/tb_rptsync_top.sv
`timescale 1ns/1ps
module tb_rptsync_top;
  localparam int PAT_W = 32;
  localparam int CNT_W = 4;
  localparam int LEN_W = $clog2(PAT_W + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_bit = 1'b0, rx_vld = 1'b0;
  logic [PAT_W-1:0] pat_word = '0;
  logic [LEN_W-1:0] pat_len = LEN_W'(7);
  logic             inv_en = 1'b0, auto_dis = 1'b0, manual_req = 1'b0;
  logic             in_sync, err_flag;
  logic [CNT_W-1:0] err_cnt;

  always #4 clk = ~clk;

  rptsync_top #(.PAT_W(PAT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .pat_word(pat_word), .pat_len(pat_len), .inv_en(inv_en),
    .auto_dis(auto_dis), .manual_req(manual_req),
    .in_sync(in_sync), .err_flag(err_flag), .err_cnt(err_cnt)
  );

  int    n_chk = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  int m_st = 0;  // 0 hunt, 1 check, 2 locked
  bit hq[$];
  int m_ptr = 0, m_vc = 0, m_wb = 0, m_we = 0, m_cnt = 0;
  bit m_flag = 0, m_man = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; hq.delete(); m_ptr = 0; m_vc = 0; m_wb = 0; m_we = 0;
      m_cnt = 0; m_flag = 0; m_man = 0;
    end else begin
      bit rise, d, bad, ok;
      int L;
      L = int'(pat_len);
      rise = manual_req && !m_man;
      m_man = manual_req;
      m_flag = 0;
      if (rise) begin
        m_st = 0; hq.delete();
      end else if (rx_vld) begin
        d = rx_bit ^ inv_en;
        if (m_st == 0) begin
          hq.push_back(d);
          if (hq.size() > PAT_W) void'(hq.pop_front());
          if (hq.size() >= L) begin
            ok = 1;
            for (int k = 0; k < L; k++)
              if (hq[hq.size() - L + k] != pat_word[k]) ok = 0;
            if (ok) begin m_st = 1; m_ptr = 0; m_vc = 0; end
          end
        end else if (m_st == 1) begin
          if (d != pat_word[m_ptr]) begin
            m_st = 0; hq.delete();
          end else begin
            m_ptr = (m_ptr + 1) % L;
            m_vc++;
            if (m_vc == 32) begin m_st = 2; m_wb = 0; m_we = 0; end
          end
        end else begin
          bad = (d != pat_word[m_ptr]);
          m_ptr = (m_ptr + 1) % L;
          if (bad) begin
            m_flag = 1;
            if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
            m_we++;
          end
          m_wb++;
          if (m_we >= 6 && !auto_dis) begin
            m_st = 0; hq.delete();
          end else if (m_wb == 64) begin
            m_wb = 0; m_we = 0;
          end
        end
      end
    end
  end

  task automatic report(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      report(cur_req, "model in_sync", int'(in_sync), (m_st == 2) ? 1 : 0);
      report(cur_req, "model err_flag", int'(err_flag), int'(m_flag));
      report(cur_req, "model err_cnt", int'(err_cnt), m_cnt);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    finish_run();
  end

  int gph = 0;

  task automatic send(bit b);
    @(negedge clk);
    rx_vld <= 1'b1;
    rx_bit <= b;
  endtask

  // n bits of the pattern, optionally all in error
  task automatic stream(int n, bit wrong = 0);
    for (int i = 0; i < n; i++) begin
      send(pat_word[gph] ^ inv_en ^ wrong);
      gph = (gph + 1) % int'(pat_len);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_vld <= 1'b0;
      rx_bit <= ~rx_bit;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rx_vld <= 1'b0;
    manual_req <= 1'b1;
    @(negedge clk);
    manual_req <= 1'b0;
    gph = 0;
  endtask

  initial begin
    pat_word = 32'h0000_0034;  // L=7: 0,0,1,0,1,1,0
    pat_len  = LEN_W'(7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    cur_req = "R1";
    report("R1", "reset in_sync", int'(in_sync), 0);
    report("R1", "reset err_cnt", int'(err_cnt), 0);
    report("R1", "reset err_flag", int'(err_flag), 0);

    // hunt at length 7: hit on bit 7, lock after 32 more
    cur_req = "R2";
    stream(38); idle(1);
    report("R2", "not locked after 38 bits", int'(in_sync), 0);
    cur_req = "R3";
    stream(1); idle(1);
    report("R3", "locked after 39 bits", int'(in_sync), 1);

    // window behaviour
    cur_req = "R5";
    stream(5, 1); stream(70); stream(5, 1); idle(1);
    report("R5", "5 errors per window keep lock", int'(in_sync), 1);
    stream(60); stream(6, 1); idle(1);
    report("R5", "6 errors in one window drop", int'(in_sync), 0);

    // check failure returns to hunt
    cur_req = "R4";
    restart();
    stream(7); stream(20); stream(1, 1); stream(15); idle(1);
    report("R4", "check mismatch prevents lock", int'(in_sync), 0);

    // auto relock disabled, counter saturation
    cur_req = "R6";
    restart();
    auto_dis = 1'b1;
    stream(39); stream(20, 1); stream(3); idle(1);
    report("R6", "lock kept with auto_dis", int'(in_sync), 1);
    cur_req = "R9";
    report("R9", "err_cnt saturates", int'(err_cnt), 15);
    stream(1, 1); idle(1);
    report("R9", "err_flag one clock after error", int'(err_flag), 1);
    idle(1);
    report("R9", "err_flag single clock", int'(err_flag), 0);

    // idle clocks change nothing
    cur_req = "R11";
    idle(10);
    report("R11", "idle keeps lock", int'(in_sync), 1);
    report("R11", "idle keeps err_flag low", int'(err_flag), 0);

    // manual edge and held level
    cur_req = "R7";
    @(negedge clk);
    rx_vld <= 1'b0;
    manual_req <= 1'b1;
    @(negedge clk);
    report("R7", "manual edge drops lock", int'(in_sync), 0);
    gph = 0;
    stream(39); idle(1);
    report("R7", "held manual_req no effect", int'(in_sync), 1);
    manual_req <= 1'b0;
    auto_dis = 1'b0;

    // inverted stream
    cur_req = "R8";
    restart();
    inv_en = 1'b1;
    stream(39); idle(1);
    report("R8", "lock on inverted stream", int'(in_sync), 1);
    inv_en = 1'b0;

    // length extremes
    cur_req = "R10";
    restart();
    pat_word = 32'h0000_0001; pat_len = LEN_W'(1);
    stream(33); idle(1);
    report("R10", "length 1 lock", int'(in_sync), 1);
    restart();
    pat_word = 32'hC5A3_9E17; pat_len = LEN_W'(32);
    stream(63); idle(1);
    report("R10", "length 32 not yet locked", int'(in_sync), 0);
    stream(1); idle(1);
    report("R10", "length 32 lock", int'(in_sync), 1);
    stream(40); stream(1, 1); idle(1);
    report("R10", "wrap keeps alignment", int'(err_cnt), 15);
    idle(2);
    finish_run();
  end
endmodule